// File: doc/BRIEF.md
# Seven-Level Stepped Waveform Angle Sequencer

This block plays back a staircase voltage command for a seven-level converter from a small table of switching angles that were solved offline. A phase counter advances on each clock-enable tick and covers one fundamental period. The counter value is folded into the first quarter period by quarter-wave and half-wave symmetry. The folded value is then compared against the ascending angle thresholds in the table. Each threshold that has been crossed moves the level by one step, up or down, as chosen by a direction bit stored with that angle. The result is a signed level from -3 to +3. The block also drives a one-hot ten-bit switch-state word and a bridge gate that is the AND of an external PWM pulse train with the non-zero-level window.

Angles and the period length are in phase-counter units. The default table is the modulation-index-1 solution at a period of 1440 counts, which is quarter-degree resolution. Table entries are written through a valid/ready write port. The port never applies back-pressure: ready is held high, and each cycle with valid high commits one entry. Writes land in a shadow copy. The shadow copy and the period length are taken into use only at the start of the next period, so one period never mixes two tables.

Top module: `she_stair_seq`

## Requirements
- R1: Out of reset the level is 0, the switch word is all zero and the bridge gate is low. This holds until the first tick, which starts the first period at phase 0.
- R2: Each tick advances the phase by one. After phase period-1 the next tick returns it to 0 and starts a new period. The period length is sampled from `period_len` only at a period start. In cycles without a tick the outputs hold.
- R3: With half = period/2, the phase is in the negative half when phase >= half, and p is the phase minus half in that case, otherwise the phase itself. The folded value is p when p <= half/2, otherwise half - p. The level is the magnitude computed from the folded value, negated in the negative half.
- R4: The magnitude is the sum over all table entries with folded value >= angle of +1 when the entry's up bit is 1 and -1 when it is 0, clamped to 0..3.
- R5: The default table is angles 81, 125, 166, 246, 258 with up bits 1, 1, 1, 0, 1, meant for a period of 1440.
- R6: A write (wr_valid high while wr_ready, which is always high) stores wr_angle and wr_up at entry wr_idx. Indices of 5 or more are ignored. The stored entry changes the output only from the next period start onward.
- R7: Once started, the switch word is one-hot with bit (3 - level) set, so +3 sets bit 0 and -3 sets bit 6. Bits 9..7 are always zero.
- R8: The bridge gate is high exactly when pwm_in is high and the level is non-zero.
- R9: For a valid table (angles ascending, above 1 and below period/4), the level never changes by more than one step between two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Phase advance enable |
| period_len | input | 16 | Period length in ticks, sampled at period start |
| wr_valid | input | 1 | Table write valid |
| wr_ready | output | 1 | Table write ready, always 1 |
| wr_idx | input | 3 | Table entry index |
| wr_angle | input | 16 | Angle threshold in phase counts |
| wr_up | input | 1 | Step direction for the entry, 1 = up |
| pwm_in | input | 1 | PWM pulse train for the bridge gate |
| lvl | output | 3 | Signed output level, -3..+3 |
| sw_state | output | 10 | One-hot switch state |
| hb_gate | output | 1 | Bridge gate |

## Verification
The phase, the period length and the active table are the only registered state. A tick at one clock edge therefore shows up in `lvl` and `sw_state` at once after that edge. `hb_gate` follows `pwm_in` in the same cycle, with no register in its path. The bench drives a tick at one falling edge, removes it at the next falling edge, and samples the outputs there, a full half cycle after the edge that moved the phase. Writes and period-length changes are placed mid-period. They are checked both before and after the following period start, which is the one edge at which they may take effect.

// File: rtl/she_pkg.sv
package she_pkg;
  localparam int LVL_MAX = 3;
  localparam int NSW     = 10;
  typedef logic signed [2:0] lvl_t;
endpackage

// File: rtl/she_angle_table.sv
module she_angle_table #(
  parameter int N_ANG = 5,
  parameter int ANG_W = 16,
  parameter int IDX_W = $clog2(N_ANG),
  parameter logic [N_ANG*ANG_W-1:0] DEF_ANG = '0,
  parameter logic [N_ANG-1:0]       DEF_UP  = '0
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [IDX_W-1:0]       wr_idx,
  input  logic [ANG_W-1:0]       wr_angle,
  input  logic                   wr_up,
  input  logic                   load,
  output logic [N_ANG*ANG_W-1:0] act_ang,
  output logic [N_ANG-1:0]       act_up
);
  for (genvar i = 0; i < N_ANG; i++) begin : g_ent
    logic [ANG_W-1:0] sh_ang;
    logic             sh_up;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        sh_ang <= DEF_ANG[i*ANG_W +: ANG_W];
        sh_up  <= DEF_UP[i];
      end else if (wr_en && wr_idx == IDX_W'(i)) begin
        sh_ang <= wr_angle;
        sh_up  <= wr_up;
      end
    end
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        act_ang[i*ANG_W +: ANG_W] <= DEF_ANG[i*ANG_W +: ANG_W];
        act_up[i]                 <= DEF_UP[i];
      end else if (load) begin
        act_ang[i*ANG_W +: ANG_W] <= sh_ang;
        act_up[i]                 <= sh_up;
      end
    end
  end
endmodule

// File: rtl/she_phase_fold.sv
module she_phase_fold #(
  parameter int PH_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick,
  input  logic [PH_W-1:0] period_len,
  output logic            start,
  output logic            running,
  output logic            neg_half,
  output logic [PH_W-1:0] fold
);
  logic [PH_W-1:0] phase, per_q, half, quart, p2;

  assign start = tick && (!running || phase == PH_W'(per_q - 1'b1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase   <= '0;
      per_q   <= '0;
      running <= 1'b0;
    end else if (start) begin
      phase   <= '0;
      per_q   <= period_len;
      running <= 1'b1;
    end else if (tick) begin
      phase <= phase + 1'b1;
    end
  end

  always_comb begin
    half     = per_q >> 1;
    quart    = half >> 1;
    neg_half = phase >= half;
    p2       = neg_half ? PH_W'(phase - half) : phase;
    fold     = (p2 > quart) ? PH_W'(half - p2) : p2;
  end
endmodule

// File: rtl/she_level_map.sv
module she_level_map
  import she_pkg::*;
#(
  parameter int N_ANG = 5,
  parameter int ANG_W = 16
) (
  input  logic [ANG_W-1:0]       fold,
  input  logic                   neg_half,
  input  logic                   running,
  input  logic [N_ANG*ANG_W-1:0] act_ang,
  input  logic [N_ANG-1:0]       act_up,
  output lvl_t                   lvl,
  output logic [NSW-1:0]         sw_state
);
  int acc, mag, k;

  always_comb begin
    acc = 0;
    for (int i = 0; i < N_ANG; i++) begin
      if (fold >= act_ang[i*ANG_W +: ANG_W]) acc = act_up[i] ? acc + 1 : acc - 1;
    end
    mag = (acc < 0) ? 0 : (acc > LVL_MAX) ? LVL_MAX : acc;
    if (!running) lvl = '0;
    else          lvl = neg_half ? lvl_t'(-mag) : lvl_t'(mag);
    k = LVL_MAX - int'(lvl);
    sw_state = running ? (NSW'(1) << k) : '0;
  end
endmodule

// File: rtl/she_stair_seq.sv
module she_stair_seq
  import she_pkg::*;
#(
  parameter int PH_W  = 16,
  parameter int N_ANG = 5,
  parameter int IDX_W = $clog2(N_ANG),
  parameter logic [N_ANG*PH_W-1:0] DEF_ANG =
    {16'd258, 16'd246, 16'd166, 16'd125, 16'd81},
  parameter logic [N_ANG-1:0] DEF_UP = 5'b10111
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick,
  input  logic [PH_W-1:0]    period_len,
  input  logic               wr_valid,
  output logic               wr_ready,
  input  logic [IDX_W-1:0]   wr_idx,
  input  logic [PH_W-1:0]    wr_angle,
  input  logic               wr_up,
  input  logic               pwm_in,
  output logic signed [2:0]  lvl,
  output logic [NSW-1:0]     sw_state,
  output logic               hb_gate
);
  logic                    start, running, neg_half;
  logic [PH_W-1:0]         fold;
  logic [N_ANG*PH_W-1:0]   act_ang;
  logic [N_ANG-1:0]        act_up;

  assign wr_ready = 1'b1;

  she_phase_fold #(.PH_W(PH_W)) u_phase (
    .clk(clk), .rst_n(rst_n), .tick(tick), .period_len(period_len),
    .start(start), .running(running), .neg_half(neg_half), .fold(fold)
  );

  she_angle_table #(
    .N_ANG(N_ANG), .ANG_W(PH_W), .IDX_W(IDX_W),
    .DEF_ANG(DEF_ANG), .DEF_UP(DEF_UP)
  ) u_table (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_valid && wr_ready),
    .wr_idx(wr_idx), .wr_angle(wr_angle), .wr_up(wr_up),
    .load(start), .act_ang(act_ang), .act_up(act_up)
  );

  she_level_map #(.N_ANG(N_ANG), .ANG_W(PH_W)) u_map (
    .fold(fold), .neg_half(neg_half), .running(running),
    .act_ang(act_ang), .act_up(act_up), .lvl(lvl), .sw_state(sw_state)
  );

  assign hb_gate = pwm_in && (lvl != '0);
endmodule

// File: rtl/she_stair_seq_chk.sv
module she_stair_seq_chk (
  input logic              clk,
  input logic              rst_n,
  input logic              tick,
  input logic              pwm_in,
  input logic signed [2:0] lvl,
  input logic [9:0]        sw_state,
  input logic              hb_gate
);
  logic started, started_d;
  logic signed [3:0] lv4, prev4;

  assign lv4 = {lvl[2], lvl};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      started   <= 1'b0;
      started_d <= 1'b0;
      prev4     <= '0;
    end else begin
      if (tick) started <= 1'b1;
      started_d <= started;
      prev4     <= lv4;
    end
  end

  assert_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !started |-> (lvl == 3'sd0 && sw_state == '0 && !hb_gate));

  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(lvl));

  assert_onehot_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sw_state) && sw_state[9:7] == 3'b000);

  assert_active_R7: assert property (@(posedge clk) disable iff (!rst_n)
    started |-> $countones(sw_state) == 1);

  assert_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
    hb_gate |-> (pwm_in && lvl != 3'sd0));

  assert_gate_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !pwm_in |-> !hb_gate);

  assert_one_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
    started_d |-> ((lv4 - prev4) <= 4'sd1 && (prev4 - lv4) <= 4'sd1));
endmodule

bind she_stair_seq she_stair_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .pwm_in(pwm_in),
  .lvl(lvl), .sw_state(sw_state), .hb_gate(hb_gate)
);

// File: tb/she_stair_seq_bench.sv
module she_stair_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 20;
  localparam int VEC_PH [NV] = '{0, 80, 81, 124, 125, 166, 246, 258, 360, 462,
                                 463, 639, 640, 719, 720, 801, 966, 1080, 1359, 1439};
  localparam int VEC_LV [NV] = '{0, 0, 1, 1, 2, 3, 2, 3, 3, 3,
                                 2, 1, 0, 0, 0, -1, -2, -3, -1, 0};

  logic clk = 0, rst_n = 0, tick = 0, wr_valid = 0, wr_up = 0, pwm_in = 0;
  logic [15:0] period_len = 16'd1440, wr_angle = '0;
  logic [2:0] wr_idx = '0;
  logic wr_ready, hb_gate;
  logic signed [2:0] lvl;
  logic [9:0] sw_state;

  int n_tests = 0, n_fail = 0, step_viol = 0;
  bit done = 0, started = 0;
  int ph = 0, per_cur = 0, prev_lv = 0;
  int sh_ang [5] = '{81, 125, 166, 246, 258};
  int sh_up  [5] = '{1, 1, 1, 0, 1};
  int ac_ang [5] = '{81, 125, 166, 246, 258};
  int ac_up  [5] = '{1, 1, 1, 0, 1};

  always #(CLK_PERIOD/2) clk = ~clk;

  she_stair_seq u_she_stair_seq (
    .clk(clk), .rst_n(rst_n), .tick(tick), .period_len(period_len),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_idx(wr_idx),
    .wr_angle(wr_angle), .wr_up(wr_up), .pwm_in(pwm_in),
    .lvl(lvl), .sw_state(sw_state), .hb_gate(hb_gate)
  );

  task automatic chk(string req, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d (phase %0d)", req, act, exp, ph);
    end
  endtask

  function automatic int model_lvl();
    int half = per_cur / 2;
    int p = ph, f, m = 0;
    bit neg = 0;
    if (p >= half) begin neg = 1; p = p - half; end
    f = (p > half / 2) ? half - p : p;
    for (int i = 0; i < 5; i++) if (f >= ac_ang[i]) m += ac_up[i] ? 1 : -1;
    if (m < 0) m = 0;
    if (m > 3) m = 3;
    return neg ? -m : m;
  endfunction

  task automatic step();
    @(negedge clk) tick = 1;
    @(negedge clk) tick = 0;
    if (!started || ph == per_cur - 1) begin
      ph = 0; per_cur = int'(period_len); started = 1;
      for (int i = 0; i < 5; i++) begin ac_ang[i] = sh_ang[i]; ac_up[i] = sh_up[i]; end
    end else ph++;
    if (int'(lvl) - prev_lv > 1 || prev_lv - int'(lvl) > 1) step_viol++;
    prev_lv = int'(lvl);
  endtask

  task automatic goto(int target);
    while (ph != target) step();
  endtask

  task automatic write_ent(int idx, int ang, bit up);
    @(negedge clk);
    wr_valid = 1; wr_idx = 3'(idx); wr_angle = 16'(ang); wr_up = up;
    @(negedge clk) wr_valid = 0;
    if (idx < 5) begin sh_ang[idx] = ang; sh_up[idx] = up; end
  endtask

  task automatic chk_model(string req);
    int e = model_lvl();
    chk(req, int'(lvl), e);
    chk("R7", int'(sw_state), 1 << (3 - e));
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_fail++; n_tests++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    pwm_in = 1;
    #1;
    chk("R1", int'(lvl), 0);
    chk("R1", int'(sw_state), 0);
    chk("R1", int'(hb_gate), 0);
    chk("R6", int'(wr_ready), 1);

    step();
    chk("R1", int'(lvl), 0);
    chk("R7", int'(sw_state), 8);

    // vector walk through the first period, default table (R3 R4 R5 R7 R8)
    for (int i = 0; i < NV; i++) begin
      goto(VEC_PH[i]);
      chk("R4", int'(lvl), VEC_LV[i]);
      chk("R7", int'(sw_state), 1 << (3 - VEC_LV[i]));
      chk("R8", int'(hb_gate), VEC_LV[i] != 0 ? 1 : 0);
      if (VEC_PH[i] == 166) begin
        repeat (3) @(negedge clk);
        chk("R2", int'(lvl), 3);
        pwm_in = 0; #1;
        chk("R8", int'(hb_gate), 0);
        pwm_in = 1;
      end
    end

    step();
    chk("R2", ph, 0);
    chk("R2", int'(lvl), 0);

    // mid-period write and period change: no effect until next start (R6, R2)
    goto(100);
    chk("R5", int'(lvl), 1);
    write_ent(0, 110, 1);
    write_ent(6, 5, 0);
    period_len = 16'd800;
    @(negedge clk);
    chk("R6", int'(lvl), 1);
    goto(1000);
    chk("R2", int'(lvl), -3);
    goto(1439);
    chk("R2", int'(lvl), 0);

    step();
    chk("R2", ph, 0);
    goto(100);
    chk("R6", int'(lvl), 0);
    goto(110);
    chk("R6", int'(lvl), 1);
    goto(250);
    chk_model("R3");
    chk("R3", int'(lvl), 2);
    goto(650);
    chk_model("R3");
    chk("R3", int'(lvl), -2);
    goto(799);
    chk("R3", int'(lvl), 0);
    step();
    chk("R2", ph, 0);
    goto(110);
    chk("R2", int'(lvl), 1);
    goto(300);
    chk_model("R4");

    chk("R9", step_viol, 0);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule